// File: doc/BRIEF.md
# Exception and Reset Entry Controller

This block decides when the processor core leaves its normal instruction flow for a reset, a fast interrupt or a normal interrupt. It then produces the complete set of writes the banked register file needs for that entry. It watches two active-high request lines and keeps one pending flag for each. It only acts on those flags when the core signals an instruction boundary. Each entry is a one-cycle pulse on `ent_valid_o`, together with four words: the new status word, the value to save into the saved-status register of the target mode, the return address for the link register, and the new program counter.

Two reset sources exist. The power-on reset is asynchronous, and one reset entry follows its release. The external reset is sampled on the clock, and one entry is performed on the first cycle it is seen high. While either reset is in progress, no interrupt entry happens and both pending flags are held clear. The fast interrupt always wins over the normal one, and each class can be masked by its own bit in the status word.

Top module: `eec_entry_ctrl`

## Requirements
- R1: On the first clock after the power-on reset is released, exactly one entry is issued with kind 1 (reset). Its new status word and its saved status are both 0x000000D3 (supervisor mode 5'b10011, I bit 7 and F bit 6 set). Its link value is the `pc_i` of that cycle and its new PC is 0.
- R2: On the first cycle the external reset is high, one reset entry is issued. The saved status is `cpsr_i` with carry (bit 29) and overflow (bit 28) cleared. The new status word is 0x000000D3, the link value is `pc_i` and the new PC is 0. Holding the reset high issues no further entry.
- R3: If the mode field `cpsr_i[4:0]` is not a valid mode when the external reset arrives, the saved status becomes 0x000000D3. The valid modes are 10000, 10001, 10010, 10011, 10111, 11011 and 11111.
- R4: While the external reset is held, no interrupt entry occurs. Pending flags are cleared, so a request line that rose during reset and stays high gives no entry after release.
- R5: A fast entry (kind 2) sets mode 10001 and both mask bits, and keeps every other status bit. The saved status is the old word, the link value is `pc_i`+4 and the new PC is 0x1C. It is taken only when the F bit of `cpsr_i` is clear.
- R6: A normal entry (kind 3) sets mode 10010 and the I bit, and leaves the F bit unchanged. The saved status is the old word, the link value is `pc_i`+4 and the new PC is 0x18. It is taken only when the I bit is clear.
- R7: When both classes are pending and unmasked, only the fast entry is taken at that boundary. At most one entry is issued per boundary.
- R8: A pending flag is raised only when its line changes from low to high. Every boundary clears both flags, so a masked request that stays high is dropped, and clearing the mask bit later without a status write gives no entry.
- R9: A status write (`cpsr_wr_i`) while a request line is high raises that line's pending flag again.
- R10: Interrupt entries appear only in the cycle after `boundary_i` was high. A pending request waits until then.
- R11: The controller's own entry counts as a status write. A fast request still high after its entry is pending again, and it is taken at the next boundary where F is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| xrst_i | input | 1 | External reset, synchronous, active high |
| fiq_req_i | input | 1 | Fast interrupt request line |
| irq_req_i | input | 1 | Normal interrupt request line |
| boundary_i | input | 1 | Instruction boundary strobe |
| cpsr_i | input | W | Current status word |
| cpsr_wr_i | input | 1 | The core wrote the status word this cycle |
| pc_i | input | W | Current program counter |
| ent_valid_o | output | 1 | One-cycle entry strobe |
| ent_kind_o | output | 2 | Entry kind: 1 reset, 2 fast, 3 normal |
| cpsr_o | output | W | New status word |
| spsr_o | output | W | Value for the saved-status register of the new mode |
| lr_o | output | W | Value for the link register of the new mode |
| pc_o | output | W | New program counter (vector) |

## Verification
The bound checker checks the shape of every entry on every cycle: the mode, mask bits, vector and return address for each kind, that interrupt entries follow a boundary and never a held reset, and that reset entries follow the release of the power-on reset and the rise of the external reset. The pending-flag history cannot be seen at the ports, so only the bench's scenarios show the following: a request that was only latched on its edge being dropped at a masked boundary, a status write re-arming a request, the fast class winning over the normal one, and a held request being taken again after the controller's own entry.

// File: rtl/eec_pkg.sv
package eec_pkg;

   typedef enum logic [1:0] {
      EK_NONE  = 2'd0,
      EK_RESET = 2'd1,
      EK_FAST  = 2'd2,
      EK_NORM  = 2'd3
   } ek_t;

   localparam logic [4:0] MD_USR = 5'b10000;
   localparam logic [4:0] MD_FIQ = 5'b10001;
   localparam logic [4:0] MD_IRQ = 5'b10010;
   localparam logic [4:0] MD_SVC = 5'b10011;
   localparam logic [4:0] MD_ABT = 5'b10111;
   localparam logic [4:0] MD_UND = 5'b11011;
   localparam logic [4:0] MD_SYS = 5'b11111;

   localparam int BIT_I = 7;
   localparam int BIT_F = 6;

   function automatic logic mode_ok(input logic [4:0] m);
      case (m)
         MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: mode_ok = 1'b1;
         default: mode_ok = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/eec_line_track.sv
module eec_line_track #(
   parameter bit DROP_ON_TAKE = 1'b0
) (
   input  logic clk,
   input  logic por_i,
   input  logic line_i,
   input  logic rst_act_i,
   input  logic boundary_i,
   input  logic status_wr_i,
   input  logic taken_i,
   output logic pend_o
);
   logic lvl_q;
   logic rise;
   logic pend_d;
   logic lvl_d;

   assign rise = line_i & ~lvl_q;

   generate
      if (DROP_ON_TAKE) begin : g_drop
         assign lvl_d = taken_i ? 1'b0 : line_i;
      end else begin : g_keep
         assign lvl_d = line_i;
      end
   endgenerate

   always_comb begin
      pend_d = pend_o;
      if (boundary_i) pend_d = 1'b0;
      if (rise || (line_i && status_wr_i)) pend_d = 1'b1;
      if (rst_act_i) pend_d = 1'b0;
   end

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         lvl_q  <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         lvl_q  <= lvl_d;
         pend_o <= pend_d;
      end
   end
endmodule

// File: rtl/eec_pick.sv
module eec_pick
   import eec_pkg::*;
#(
   parameter bit NORM_EN = 1'b1
) (
   input  logic por_due_i,
   input  logic xrst_i,
   input  logic xrst_q_i,
   input  logic boundary_i,
   input  logic pend_fast_i,
   input  logic pend_norm_i,
   input  logic mask_f_i,
   input  logic mask_i_i,
   output ek_t  kind_o
);
   logic norm_ok;

   generate
      if (NORM_EN) begin : g_norm
         assign norm_ok = pend_norm_i & ~mask_i_i;
      end else begin : g_nonorm
         assign norm_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      kind_o = EK_NONE;
      if (por_due_i) begin
         kind_o = EK_RESET;
      end else if (xrst_i) begin
         if (!xrst_q_i) kind_o = EK_RESET;
      end else if (boundary_i) begin
         if (pend_fast_i && !mask_f_i) kind_o = EK_FAST;
         else if (norm_ok)             kind_o = EK_NORM;
      end
   end
endmodule

// File: rtl/eec_frame.sv
module eec_frame
   import eec_pkg::*;
#(
   parameter int             W       = 32,
   parameter int             RET_OFS = 4,
   parameter int             C_BIT   = 29,
   parameter int             V_BIT   = 28,
   parameter logic [W-1:0]   RST_VEC = '0,
   parameter logic [W-1:0]   FIQ_VEC = W'(32'h1C),
   parameter logic [W-1:0]   IRQ_VEC = W'(32'h18)
) (
   input  ek_t          kind_i,
   input  logic         por_due_i,
   input  logic [W-1:0] cpsr_i,
   input  logic [W-1:0] pc_i,
   output logic [W-1:0] cpsr_n,
   output logic [W-1:0] spsr_n,
   output logic [W-1:0] lr_n,
   output logic [W-1:0] pc_n
);
   localparam logic [W-1:0] RST_WORD = {{(W-8){1'b0}}, 8'hD3};
   localparam logic [W-1:0] CV_MASK  = ~((W'(1) << C_BIT) | (W'(1) << V_BIT));

   logic [W-1:0] saved_rst;
   logic [W-1:0] ret_addr;

   assign ret_addr = pc_i + W'(RET_OFS);

   always_comb begin
      if (por_due_i || !mode_ok(cpsr_i[4:0])) saved_rst = RST_WORD;
      else                                     saved_rst = cpsr_i & CV_MASK;
   end

   always_comb begin
      cpsr_n = '0;
      spsr_n = '0;
      lr_n   = '0;
      pc_n   = '0;
      case (kind_i)
         EK_RESET: begin
            cpsr_n = RST_WORD;
            spsr_n = saved_rst;
            lr_n   = pc_i;
            pc_n   = RST_VEC;
         end
         EK_FAST: begin
            cpsr_n = {cpsr_i[W-1:8], 1'b1, 1'b1, cpsr_i[5], MD_FIQ};
            spsr_n = cpsr_i;
            lr_n   = ret_addr;
            pc_n   = FIQ_VEC;
         end
         EK_NORM: begin
            cpsr_n = {cpsr_i[W-1:8], 1'b1, cpsr_i[BIT_F], cpsr_i[5], MD_IRQ};
            spsr_n = cpsr_i;
            lr_n   = ret_addr;
            pc_n   = IRQ_VEC;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/eec_entry_ctrl.sv
module eec_entry_ctrl
   import eec_pkg::*;
#(
   parameter int           W       = 32,
   parameter bit           NORM_EN = 1'b1,
   parameter int           RET_OFS = 4,
   parameter int           C_BIT   = 29,
   parameter int           V_BIT   = 28,
   parameter logic [W-1:0] RST_VEC = '0,
   parameter logic [W-1:0] FIQ_VEC = W'(32'h1C),
   parameter logic [W-1:0] IRQ_VEC = W'(32'h18)
) (
   input  logic         clk,
   input  logic         por_i,
   input  logic         xrst_i,
   input  logic         fiq_req_i,
   input  logic         irq_req_i,
   input  logic         boundary_i,
   input  logic [W-1:0] cpsr_i,
   input  logic         cpsr_wr_i,
   input  logic [W-1:0] pc_i,
   output logic         ent_valid_o,
   output logic [1:0]   ent_kind_o,
   output logic [W-1:0] cpsr_o,
   output logic [W-1:0] spsr_o,
   output logic [W-1:0] lr_o,
   output logic [W-1:0] pc_o
);
   generate
      if (W < 8)          begin : g_bad_w  $error("W must hold mode and mask bits"); end
      if (C_BIT >= W)     begin : g_bad_c  $error("C_BIT outside status word");      end
      if (V_BIT >= W)     begin : g_bad_v  $error("V_BIT outside status word");      end
      if (C_BIT <= 7)     begin : g_bad_c2 $error("C_BIT overlaps control field");   end
      if (V_BIT <= 7)     begin : g_bad_v2 $error("V_BIT overlaps control field");   end
   endgenerate

   logic   por_due_q;
   logic   xrst_q;
   logic   rst_act;
   logic   pend_fast;
   logic   pend_norm;
   logic   own_wr;
   logic   status_wr;
   ek_t    kind;
   logic [W-1:0] cpsr_n, spsr_n, lr_n, pc_n;

   assign rst_act   = por_due_q | xrst_i;
   assign own_wr    = (kind != EK_NONE);
   assign status_wr = cpsr_wr_i | own_wr;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         por_due_q <= 1'b1;
         xrst_q    <= 1'b0;
      end else begin
         por_due_q <= 1'b0;
         xrst_q    <= xrst_i;
      end
   end

   eec_line_track #(.DROP_ON_TAKE(1'b0)) u_fast (
      .clk         (clk),
      .por_i       (por_i),
      .line_i      (fiq_req_i),
      .rst_act_i   (rst_act),
      .boundary_i  (boundary_i),
      .status_wr_i (status_wr),
      .taken_i     (kind == EK_FAST),
      .pend_o      (pend_fast)
   );

   generate
      if (NORM_EN) begin : g_norm_trk
         eec_line_track #(.DROP_ON_TAKE(1'b1)) u_norm (
            .clk         (clk),
            .por_i       (por_i),
            .line_i      (irq_req_i),
            .rst_act_i   (rst_act),
            .boundary_i  (boundary_i),
            .status_wr_i (status_wr),
            .taken_i     (kind == EK_NORM),
            .pend_o      (pend_norm)
         );
      end else begin : g_no_norm
         logic unused_irq;
         assign unused_irq = irq_req_i;
         assign pend_norm  = 1'b0;
      end
   endgenerate

   eec_pick #(.NORM_EN(NORM_EN)) u_pick (
      .por_due_i   (por_due_q),
      .xrst_i      (xrst_i),
      .xrst_q_i    (xrst_q),
      .boundary_i  (boundary_i),
      .pend_fast_i (pend_fast),
      .pend_norm_i (pend_norm),
      .mask_f_i    (cpsr_i[BIT_F]),
      .mask_i_i    (cpsr_i[BIT_I]),
      .kind_o      (kind)
   );

   eec_frame #(
      .W(W), .RET_OFS(RET_OFS), .C_BIT(C_BIT), .V_BIT(V_BIT),
      .RST_VEC(RST_VEC), .FIQ_VEC(FIQ_VEC), .IRQ_VEC(IRQ_VEC)
   ) u_frame (
      .kind_i    (kind),
      .por_due_i (por_due_q),
      .cpsr_i    (cpsr_i),
      .pc_i      (pc_i),
      .cpsr_n    (cpsr_n),
      .spsr_n    (spsr_n),
      .lr_n      (lr_n),
      .pc_n      (pc_n)
   );

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         ent_valid_o <= 1'b0;
         ent_kind_o  <= EK_NONE;
         cpsr_o      <= '0;
         spsr_o      <= '0;
         lr_o        <= '0;
         pc_o        <= '0;
      end else begin
         ent_valid_o <= own_wr;
         ent_kind_o  <= kind;
         if (own_wr) begin
            cpsr_o <= cpsr_n;
            spsr_o <= spsr_n;
            lr_o   <= lr_n;
            pc_o   <= pc_n;
         end
      end
   end
endmodule

// File: rtl/eec_entry_chk.sv
module eec_entry_chk #(
   parameter int           W       = 32,
   parameter int           RET_OFS = 4,
   parameter logic [W-1:0] RST_VEC = '0,
   parameter logic [W-1:0] FIQ_VEC = W'(32'h1C),
   parameter logic [W-1:0] IRQ_VEC = W'(32'h18)
) (
   input logic         clk,
   input logic         por_i,
   input logic         xrst_i,
   input logic         boundary_i,
   input logic [W-1:0] cpsr_i,
   input logic [W-1:0] pc_i,
   input logic         ent_valid_o,
   input logic [1:0]   ent_kind_o,
   input logic [W-1:0] cpsr_o,
   input logic [W-1:0] spsr_o,
   input logic [W-1:0] lr_o,
   input logic [W-1:0] pc_o
);
   localparam logic [W-1:0] RST_WORD = {{(W-8){1'b0}}, 8'hD3};

   assert_por_entry_R1: assert property (@(posedge clk) disable iff (por_i)
      (!por_i && $past(por_i)) |=> (ent_valid_o && ent_kind_o == 2'd1 &&
         cpsr_o == RST_WORD && spsr_o == RST_WORD && pc_o == RST_VEC));

   assert_xrst_entry_R2: assert property (@(posedge clk) disable iff (por_i)
      (!$past(por_i) && xrst_i && !$past(xrst_i)) |=> (ent_valid_o && ent_kind_o == 2'd1 &&
         cpsr_o == RST_WORD && pc_o == RST_VEC && lr_o == $past(pc_i)));

   assert_held_reset_quiet_R4: assert property (@(posedge clk) disable iff (por_i)
      (xrst_i && $past(xrst_i)) |=> !(ent_valid_o && ent_kind_o != 2'd1));

   assert_fast_frame_R5: assert property (@(posedge clk) disable iff (por_i)
      (ent_valid_o && ent_kind_o == 2'd2) |-> (cpsr_o[7:6] == 2'b11 &&
         cpsr_o[4:0] == 5'b10001 && pc_o == FIQ_VEC && !$past(cpsr_i[6]) &&
         spsr_o == $past(cpsr_i) && lr_o == $past(pc_i) + W'(RET_OFS)));

   assert_norm_frame_R6: assert property (@(posedge clk) disable iff (por_i)
      (ent_valid_o && ent_kind_o == 2'd3) |-> (cpsr_o[7] && cpsr_o[6] == $past(cpsr_i[6]) &&
         cpsr_o[4:0] == 5'b10010 && pc_o == IRQ_VEC && !$past(cpsr_i[7]) &&
         spsr_o == $past(cpsr_i) && lr_o == $past(pc_i) + W'(RET_OFS)));

   assert_irq_on_boundary_R10: assert property (@(posedge clk) disable iff (por_i)
      (ent_valid_o && ent_kind_o[1]) |-> ($past(boundary_i) && !$past(xrst_i)));

   assert_kind_present_R7: assert property (@(posedge clk) disable iff (por_i)
      ent_valid_o |-> (ent_kind_o != 2'd0));
endmodule

bind eec_entry_ctrl eec_entry_chk #(
   .W(W), .RET_OFS(RET_OFS), .RST_VEC(RST_VEC), .FIQ_VEC(FIQ_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
   .clk(clk), .por_i(por_i), .xrst_i(xrst_i), .boundary_i(boundary_i),
   .cpsr_i(cpsr_i), .pc_i(pc_i), .ent_valid_o(ent_valid_o), .ent_kind_o(ent_kind_o),
   .cpsr_o(cpsr_o), .spsr_o(spsr_o), .lr_o(lr_o), .pc_o(pc_o)
);

// File: tb/sim_eec_entry_ctrl.sv
module sim_eec_entry_ctrl;
   logic        clk = 1'b0;
   logic        por_i = 1'b1;
   logic        xrst_i = 1'b0;
   logic        fiq_req_i = 1'b0;
   logic        irq_req_i = 1'b0;
   logic        boundary_i = 1'b0;
   logic [31:0] cpsr_i = 32'hD3;
   logic        cpsr_wr_i = 1'b0;
   logic [31:0] pc_i = 32'h0;
   logic        ent_valid_o;
   logic [1:0]  ent_kind_o;
   logic [31:0] cpsr_o, spsr_o, lr_o, pc_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   eec_entry_ctrl u0 (
      .clk(clk), .por_i(por_i), .xrst_i(xrst_i), .fiq_req_i(fiq_req_i),
      .irq_req_i(irq_req_i), .boundary_i(boundary_i), .cpsr_i(cpsr_i),
      .cpsr_wr_i(cpsr_wr_i), .pc_i(pc_i), .ent_valid_o(ent_valid_o),
      .ent_kind_o(ent_kind_o), .cpsr_o(cpsr_o), .spsr_o(spsr_o),
      .lr_o(lr_o), .pc_o(pc_o)
   );

   function automatic logic [31:0] exp_fast(input logic [31:0] s);
      return {s[31:8], 2'b11, s[5], 5'b10001};
   endfunction
   function automatic logic [31:0] exp_norm(input logic [31:0] s);
      return {s[31:8], 1'b1, s[6], s[5], 5'b10010};
   endfunction

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_entry(input string req, input logic [1:0] k, input logic [31:0] c,
                            input logic [31:0] s, input logic [31:0] l, input logic [31:0] p);
      chk(ent_valid_o == 1'b1, req, {31'd0, ent_valid_o}, 32'd1);
      chk(ent_kind_o == k, req, {30'd0, ent_kind_o}, {30'd0, k});
      chk(cpsr_o == c, req, cpsr_o, c);
      chk(spsr_o == s, req, spsr_o, s);
      chk(lr_o == l, req, lr_o, l);
      chk(pc_o == p, req, pc_o, p);
   endtask

   task automatic chk_none(input string req);
      chk(ent_valid_o == 1'b0, req, {31'd0, ent_valid_o}, 32'd0);
   endtask

   task automatic cleanup;
      fiq_req_i  = 1'b0;
      irq_req_i  = 1'b0;
      cpsr_i     = 32'hD3;
      boundary_i = 1'b1;
      tick();
      boundary_i = 1'b0;
      tick();
   endtask

   task automatic boundary_tick;
      boundary_i = 1'b1;
      tick();
      boundary_i = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      pc_i = 32'h0000_1234;
      repeat (3) @(negedge clk);
      chk_none("R1 reset state");
      por_i = 1'b0;
      tick();
      chk_entry("R1 power-on entry", 2'd1, 32'hD3, 32'hD3, 32'h0000_1234, 32'h0);
      tick();
      chk_none("R1 single entry");

      // R2 external reset, carry and overflow cleared in saved word
      cpsr_i = 32'hF000_0010;
      pc_i   = 32'h0000_0400;
      xrst_i = 1'b1;
      tick();
      chk_entry("R2 external reset entry", 2'd1, 32'hD3, 32'hC000_0010, 32'h0000_0400, 32'h0);
      // R4 held reset blocks interrupts and clears pending
      cpsr_i = 32'h10;
      fiq_req_i = 1'b1;
      boundary_tick();
      chk_none("R4 held reset quiet");
      xrst_i = 1'b0;
      tick();
      chk_none("R4 release");
      boundary_tick();
      chk_none("R4 pending cleared by reset");
      cleanup();

      // R3 invalid mode fallback
      cpsr_i = 32'h0000_0015;
      pc_i   = 32'h0000_0800;
      xrst_i = 1'b1;
      tick();
      chk_entry("R3 invalid mode fallback", 2'd1, 32'hD3, 32'hD3, 32'h0000_0800, 32'h0);
      xrst_i = 1'b0;
      tick();
      cleanup();

      // R7 fast over normal, one entry per boundary
      cpsr_i = 32'h10;
      pc_i   = 32'h0000_2000;
      fiq_req_i = 1'b1;
      irq_req_i = 1'b1;
      tick();
      boundary_tick();
      chk_entry("R7 fast wins", 2'd2, 32'hD1, 32'h10, 32'h0000_2004, 32'h1C);
      cpsr_i = 32'hD1;
      boundary_tick();
      chk_none("R7 no second entry while masked");
      cleanup();

      // R8 edge-only latching, dropped at masked boundary
      cpsr_i = 32'h50;
      pc_i   = 32'h0000_3000;
      fiq_req_i = 1'b1;
      tick();
      boundary_tick();
      chk_none("R8 masked fast not taken");
      cpsr_i = 32'h10;
      tick();
      boundary_tick();
      chk_none("R8 unmask without write gives nothing");
      // R9 status write re-arms
      cpsr_wr_i = 1'b1;
      tick();
      cpsr_wr_i = 1'b0;
      boundary_tick();
      chk_entry("R9 status write re-arms", 2'd2, 32'hD1, 32'h10, 32'h0000_3004, 32'h1C);
      cleanup();

      // R11 own entry re-arms a held request
      cpsr_i = 32'h10;
      pc_i   = 32'h0000_4000;
      fiq_req_i = 1'b1;
      tick();
      boundary_tick();
      chk_entry("R11 first entry", 2'd2, 32'hD1, 32'h10, 32'h0000_4004, 32'h1C);
      cpsr_i = 32'h10;
      boundary_tick();
      chk_entry("R11 held request taken again", 2'd2, 32'hD1, 32'h10, 32'h0000_4004, 32'h1C);
      cleanup();

      // Random trials over both classes, masks and status contents
      for (int t = 0; t < 60; t++) begin
         logic [31:0] sr;
         logic [31:0] pc;
         bit          fast;
         bit          take;
         int          waits;
         sr = $urandom();
         case ($urandom() % 3)
            0:       sr[4:0] = 5'b10000;
            1:       sr[4:0] = 5'b10011;
            default: sr[4:0] = 5'b11111;
         endcase
         pc    = $urandom() & 32'hFFFF_FFFC;
         fast  = ($urandom() % 2) == 0;
         waits = $urandom() % 3;
         cpsr_i = sr;
         pc_i   = pc;
         if (fast) fiq_req_i = 1'b1;
         else      irq_req_i = 1'b1;
         tick();
         chk_none("R10 no entry before boundary");
         for (int w = 0; w < waits; w++) begin
            tick();
            chk_none("R10 pending waits");
         end
         boundary_tick();
         take = fast ? !sr[6] : !sr[7];
         if (take && fast)
            chk_entry("R5 fast entry", 2'd2, exp_fast(sr), sr, pc + 32'd4, 32'h1C);
         else if (take)
            chk_entry("R6 normal entry", 2'd3, exp_norm(sr), sr, pc + 32'd4, 32'h18);
         else
            chk_none(fast ? "R5 masked fast" : "R6 masked normal");
         cleanup();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule